// File: doc/BRIEF.md
# EEPROM Acknowledge Polling Controller

After a serial EEPROM accepts a page write, it spends an internal programming period during which it ignores its bus address. This controller finds out when that period has ended. It repeatedly probes the device with an address-only I2C transaction and treats a not-acknowledge as "still busy". Each probe is a START, the device address byte with the direction bit at write, the acknowledge slot, and a STOP. If the device is still busy, the controller waits a programmed number of clock cycles and then probes again. Polling ends on the first acknowledge, or when a programmed number of probes has been used up.

The controller does not drive the bus pins. It sends one-cycle requests to a byte-level I2C master, and that master reports the completion of each request with a one-cycle pulse. When a byte request completes, the master also reports whether the byte was acknowledged. Software or a sequencer raises the start input once. It then waits for the done pulse and reads the ready and timeout flags.

Top module: `ackpoll_ctrl`

## Requirements
- R1: While reset is held and after its release, poll_done, poll_ready, poll_timeout, poll_busy and m_req are all low.
- R2: A probe issues three requests in order, each a single-cycle m_req pulse: START (m_op=0), BYTE (m_op=1) with m_byte = {dev_addr, 1'b0}, then STOP (m_op=2). No request is issued while an earlier one has not yet completed with m_done.
- R3: A START request is issued only after bus_free was high in the preceding cycle; while bus_free stays low, the run waits with poll_busy high.
- R4: When the BYTE completion reports m_ack=1 (device acknowledged), the run ends after that probe's STOP with poll_done and poll_ready, and no further probe is made.
- R5: When the BYTE completion reports m_ack=0, the next START request appears exactly wait_cycles+3 clock cycles after the cycle that reports completion of the STOP, provided bus_free is high.
- R6: After retry_limit probes that all end in m_ack=0, the run ends with poll_done and poll_timeout, and exactly retry_limit probes have been made.
- R7: A retry_limit of zero ends the run with poll_done and poll_timeout and no request at all.
- R8: retry_limit, wait_cycles and dev_addr are captured in the cycle poll_start is accepted; changing them during a run has no effect on that run.
- R9: poll_start is ignored while poll_busy is high: the run in progress keeps its probe count and reports poll_done once.
- R10: poll_done is a one-cycle pulse; exactly one of poll_ready and poll_timeout is high with it, and that flag holds until the next accepted poll_start clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_start | input | 1 | Begin a polling run (accepted when idle) |
| dev_addr | input | 7 | 7-bit device address |
| retry_limit | input | CNT_W | Maximum number of probes |
| wait_cycles | input | WAIT_W | Idle cycles inserted after a busy probe |
| bus_free | input | 1 | High when the I2C bus is idle |
| m_req | output | 1 | One-cycle request to the byte master |
| m_op | output | 2 | Request kind: 0 START, 1 BYTE, 2 STOP |
| m_byte | output | 8 | Byte to send with a BYTE request |
| m_done | input | 1 | One-cycle completion pulse from the byte master |
| m_ack | input | 1 | With m_done after BYTE: 1 = acknowledged |
| poll_done | output | 1 | One-cycle end-of-run pulse |
| poll_ready | output | 1 | Run ended on an acknowledge |
| poll_timeout | output | 1 | Run ended with the probe budget used up |
| poll_busy | output | 1 | A run is in progress |

## Verification
The hardest state to reach from the ports is the last allowed probe ending in a not-acknowledge, with that probe's budget set by values captured earlier and since overwritten. The bench's byte-master model answers a scripted number of BYTE requests with a not-acknowledge. One run changes retry_limit and wait_cycles on the cycle after start, so the exhaustion point and the gap length show whether the captured values were used. The model also measures every gap between a STOP completion and the next START to the cycle. It holds bus_free low across a run start to show that the START is withheld.

// File: rtl/ackpoll_pkg.sv
// Shared types for the acknowledge polling controller.
package ackpoll_pkg;

    // Request kinds sent to the byte-level master.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } mop_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_BUSWAIT  = 4'd1,
        S_REQ_STA  = 4'd2,
        S_WT_STA   = 4'd3,
        S_REQ_ADR  = 4'd4,
        S_WT_ADR   = 4'd5,
        S_REQ_STO  = 4'd6,
        S_WT_STO   = 4'd7,
        S_GAP      = 4'd8,
        S_FIN      = 4'd9
    } pst_e;

endpackage

// File: rtl/ackpoll_interval.sv
// Inter-probe wait timer.
// Captures the wait length when a run is accepted, reloads it after each
// busy probe and counts down while enabled.
// Assumes cap and load are never high in the same cycle.
module ackpoll_interval #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [WAIT_W-1:0] wait_in,
    input  logic              load,
    input  logic              run,
    output logic              expired
);

    logic [WAIT_W-1:0] len_q;
    logic [WAIT_W-1:0] cnt_q;

    // Capture the wait length for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (cap)
            len_q <= wait_in;
    end

    // Load the countdown after a busy probe, then decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len_q;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ackpoll_tally.sv
// Probe budget tracker.
// Captures the probe limit when a run is accepted and counts completed busy
// probes. It flags a zero budget and the probe that would use the budget up.
module ackpoll_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             inc,
    output logic             lim_zero,
    output logic             last_probe
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_cnt;

    // Capture the limit and clear the count at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (cap) begin
            lim_q <= limit_in;
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign next_cnt   = {1'b0, cnt_q} + EXT_W'(1);
    assign last_probe = (next_cnt == {1'b0, lim_q});
    assign lim_zero   = (lim_q == '0);

endmodule

// File: rtl/ackpoll_seq.sv
// Polling sequencer.
// Steps through START, address byte and STOP requests for each probe. It
// holds every request until the master reports completion, and gates each
// START on a free bus. It decides between another probe, ready and timeout.
// Assumes m_done pulses for one cycle per request and m_ack is valid with
// m_done.
module ackpoll_seq
    import ackpoll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_free,
    input  logic m_done,
    input  logic m_ack,
    input  logic lim_zero,
    input  logic last_probe,
    input  logic tmr_expired,
    output logic cap,
    output logic inc,
    output logic load,
    output logic run,
    output logic m_req,
    output mop_e m_op,
    output logic done,
    output logic busy,
    output logic ready,
    output logic timeout
);

    pst_e state_q;
    pst_e state_d;
    logic ack_q;

    // Next-state and strobe decode.
    always_comb begin
        state_d = state_q;
        cap     = 1'b0;
        inc     = 1'b0;
        load    = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    cap     = 1'b1;
                    state_d = S_BUSWAIT;
                end
            end
            S_BUSWAIT: begin
                if (lim_zero)
                    state_d = S_FIN;
                else if (bus_free)
                    state_d = S_REQ_STA;
            end
            S_REQ_STA: state_d = S_WT_STA;
            S_WT_STA:  if (m_done) state_d = S_REQ_ADR;
            S_REQ_ADR: state_d = S_WT_ADR;
            S_WT_ADR:  if (m_done) state_d = S_REQ_STO;
            S_REQ_STO: state_d = S_WT_STO;
            S_WT_STO: begin
                if (m_done) begin
                    if (ack_q) begin
                        state_d = S_FIN;
                    end else begin
                        inc = 1'b1;
                        if (last_probe) begin
                            state_d = S_FIN;
                        end else begin
                            load    = 1'b1;
                            state_d = S_GAP;
                        end
                    end
                end
            end
            S_GAP: begin
                run = 1'b1;
                if (tmr_expired)
                    state_d = S_BUSWAIT;
            end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Keep the acknowledge result of the address byte for the STOP decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (cap)
            ack_q <= 1'b0;
        else if ((state_q == S_WT_ADR) && m_done)
            ack_q <= m_ack;
    end

    // Outcome flags: cleared on an accepted start, set on entry to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b0;
            timeout <= 1'b0;
        end else if (cap) begin
            ready   <= 1'b0;
            timeout <= 1'b0;
        end else if ((state_q == S_BUSWAIT) && lim_zero) begin
            timeout <= 1'b1;
        end else if ((state_q == S_WT_STO) && m_done) begin
            if (ack_q)
                ready <= 1'b1;
            else if (last_probe)
                timeout <= 1'b1;
        end
    end

    // Request decode towards the byte master.
    always_comb begin
        m_req = 1'b0;
        m_op  = OP_START;
        case (state_q)
            S_REQ_STA: begin m_req = 1'b1; m_op = OP_START; end
            S_REQ_ADR: begin m_req = 1'b1; m_op = OP_BYTE;  end
            S_REQ_STO: begin m_req = 1'b1; m_op = OP_STOP;  end
            default:   begin m_req = 1'b0; m_op = OP_START; end
        endcase
    end

    assign done = (state_q == S_FIN);
    assign busy = (state_q != S_IDLE);

endmodule

// File: rtl/ackpoll_ctrl.sv
// EEPROM acknowledge polling controller, top level.
// Probes a device with address-only write transactions through a byte-level
// I2C master until it acknowledges or the probe budget is spent.
// Assumes the master accepts one request per m_req pulse and answers each
// with a single m_done pulse.
module ackpoll_ctrl
    import ackpoll_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_start,
    input  logic [6:0]        dev_addr,
    input  logic [CNT_W-1:0]  retry_limit,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic              bus_free,
    output logic              m_req,
    output logic [1:0]        m_op,
    output logic [7:0]        m_byte,
    input  logic              m_done,
    input  logic              m_ack,
    output logic              poll_done,
    output logic              poll_ready,
    output logic              poll_timeout,
    output logic              poll_busy
);

    localparam logic DIR_WRITE = 1'b0;

    logic cap, inc, load, run;
    logic lim_zero, last_probe, tmr_expired;
    logic [6:0] addr_q;
    mop_e op_w;

    // Hold the device address for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (cap)
            addr_q <= dev_addr;
    end

    ackpoll_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (poll_start),
        .bus_free    (bus_free),
        .m_done      (m_done),
        .m_ack       (m_ack),
        .lim_zero    (lim_zero),
        .last_probe  (last_probe),
        .tmr_expired (tmr_expired),
        .cap         (cap),
        .inc         (inc),
        .load        (load),
        .run         (run),
        .m_req       (m_req),
        .m_op        (op_w),
        .done        (poll_done),
        .busy        (poll_busy),
        .ready       (poll_ready),
        .timeout     (poll_timeout)
    );

    ackpoll_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .limit_in   (retry_limit),
        .inc        (inc),
        .lim_zero   (lim_zero),
        .last_probe (last_probe)
    );

    ackpoll_interval #(.WAIT_W(WAIT_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .wait_in (wait_cycles),
        .load    (load),
        .run     (run),
        .expired (tmr_expired)
    );

    assign m_op   = op_w;
    assign m_byte = {addr_q, DIR_WRITE};

endmodule

// File: rtl/ackpoll_ctrl_chk.sv
// Protocol checker for ackpoll_ctrl, attached by bind.
// Tracks outstanding master requests and checks request framing, bus
// gating and outcome reporting.
module ackpoll_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_start,
    input logic       bus_free,
    input logic       m_req,
    input logic [1:0] m_op,
    input logic       m_done,
    input logic       poll_done,
    input logic       poll_ready,
    input logic       poll_timeout,
    input logic       poll_busy
);

    logic pend_q;

    // Outstanding-request tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (m_req)
            pend_q <= 1'b1;
        else if (m_done)
            pend_q <= 1'b0;
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !pend_q); // R2
    AST_START_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && (m_op == 2'd0)) |-> $past(bus_free)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_busy |-> !m_req); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> (poll_ready ^ poll_timeout)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |=> !poll_done); // R10
    AST_OUTCOME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_busy && !poll_start && $past(!poll_busy))
            |-> ($stable(poll_ready) && $stable(poll_timeout))); // R10

endmodule

bind ackpoll_ctrl ackpoll_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .poll_start   (poll_start),
    .bus_free     (bus_free),
    .m_req        (m_req),
    .m_op         (m_op),
    .m_done       (m_done),
    .poll_done    (poll_done),
    .poll_ready   (poll_ready),
    .poll_timeout (poll_timeout),
    .poll_busy    (poll_busy)
);

// File: tb/ackpoll_ctrl_tb.sv
module ackpoll_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int WAIT_W = 16;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic poll_start = 1'b0;
    logic [6:0] dev_addr = 7'h53;
    logic [CNT_W-1:0] retry_limit = '0;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic bus_free = 1'b1;
    logic m_done = 1'b0;
    logic m_ack = 1'b0;
    logic m_req;
    logic [1:0] m_op;
    logic [7:0] m_byte;
    logic poll_done, poll_ready, poll_timeout, poll_busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic stats_clr = 1'b0;
    int nack_cfg = 0;

    int probes, order_err, byte_err, bus_err, overlap_err, done_cnt, last_gap, gap_cnt, nack_left, dly;
    bit gap_on, pend;
    logic [1:0] pend_op, exp_op;

    always #(CLK_PERIOD/2) clk = ~clk;

    ackpoll_ctrl #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .poll_start(poll_start), .dev_addr(dev_addr),
        .retry_limit(retry_limit), .wait_cycles(wait_cycles), .bus_free(bus_free),
        .m_req(m_req), .m_op(m_op), .m_byte(m_byte), .m_done(m_done), .m_ack(m_ack),
        .poll_done(poll_done), .poll_ready(poll_ready), .poll_timeout(poll_timeout),
        .poll_busy(poll_busy)
    );

    // Byte-master model and observer, acting away from the active edge.
    always @(negedge clk) begin
        m_done = 1'b0;
        if (stats_clr) begin
            probes = 0; order_err = 0; byte_err = 0; bus_err = 0; overlap_err = 0;
            done_cnt = 0; last_gap = -1; gap_cnt = 0; gap_on = 0; exp_op = 2'd0;
            nack_left = nack_cfg;
        end
        if (poll_done) done_cnt++;
        if (gap_on) gap_cnt++;
        if (m_req) begin
            if (pend) overlap_err++;
            if (m_op != exp_op) order_err++;
            exp_op = (m_op == 2'd2) ? 2'd0 : m_op + 2'd1;
            if (m_op == 2'd0) begin
                probes++;
                if (!bus_free) bus_err++;
                if (gap_on) begin last_gap = gap_cnt; gap_on = 0; end
            end
            if (m_op == 2'd1 && m_byte != {dev_addr, 1'b0}) byte_err++;
            pend = 1; dly = LAT; pend_op = m_op;
        end else if (pend) begin
            dly--;
            if (dly == 0) begin
                m_done = 1'b1;
                pend = 0;
                if (pend_op == 2'd1) begin
                    if (nack_left > 0) begin m_ack = 1'b0; nack_left--; end
                    else m_ack = 1'b1;
                end
                if (pend_op == 2'd2) begin gap_on = 1; gap_cnt = 0; end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input int lim, input int w, input int nacks);
        @(negedge clk);
        retry_limit = CNT_W'(lim); wait_cycles = WAIT_W'(w); nack_cfg = nacks;
        stats_clr = 1'b1;
        @(negedge clk);
        stats_clr = 1'b0;
        poll_start = 1'b1;
        @(negedge clk);
        poll_start = 1'b0;
    endtask

    task automatic wait_fin(output int rdy, output int tmo);
        rdy = -1; tmo = -1;
        for (int i = 0; i < 5000; i++) begin
            if (poll_done) begin rdy = int'(poll_ready); tmo = int'(poll_timeout); break; end
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_clean(input string req);
        chk(req, "request order errors", order_err, 0);
        chk(req, "overlapping requests", overlap_err, 0);
        chk(req, "address byte errors", byte_err, 0);
        chk(req, "done pulses", done_cnt, 1);
    endtask

    task automatic sc_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(poll_done), 0);
        chk("R1", "busy in reset", int'(poll_busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "ready after reset", int'(poll_ready), 0);
        chk("R1", "timeout after reset", int'(poll_timeout), 0);
        chk("R1", "request after reset", int'(m_req), 0);
    endtask

    task automatic sc_quick_ack;
        int r, t;
        launch(5, 4, 0);
        wait_fin(r, t);
        chk("R4", "ready on ack", r, 1);
        chk("R4", "timeout on ack", t, 0);
        chk("R4", "probes on first ack", probes, 1);
        chk_clean("R2");
    endtask

    task automatic sc_nack_then_ack;
        int r, t;
        launch(8, 6, 3);
        chk("R10", "ready cleared by start", int'(poll_ready), 0);
        wait_fin(r, t);
        chk("R5", "ready after busy probes", r, 1);
        chk("R5", "probes", probes, 4);
        chk("R5", "gap cycles", last_gap, 9);
        chk_clean("R5");
    endtask

    task automatic sc_exhaust;
        int r, t;
        launch(4, 0, 10);
        wait_fin(r, t);
        chk("R6", "timeout flag", t, 1);
        chk("R6", "ready flag", r, 0);
        chk("R6", "probes", probes, 4);
        chk("R5", "gap with zero wait", last_gap, 3);
        chk_clean("R6");
    endtask

    task automatic sc_zero_limit;
        int r, t;
        launch(0, 5, 0);
        wait_fin(r, t);
        chk("R7", "timeout flag", t, 1);
        chk("R7", "ready flag", r, 0);
        chk("R7", "probes", probes, 0);
        chk("R7", "done pulses", done_cnt, 1);
    endtask

    task automatic sc_latch;
        int r, t;
        launch(3, 10, 10);
        retry_limit = CNT_W'(9); wait_cycles = WAIT_W'(1);
        wait_fin(r, t);
        chk("R8", "timeout with captured limit", t, 1);
        chk("R8", "probes with captured limit", probes, 3);
        chk("R8", "gap with captured wait", last_gap, 13);
    endtask

    task automatic sc_busy_start;
        int r, t;
        launch(6, 2, 2);
        repeat (6) @(negedge clk);
        poll_start = 1'b1;
        @(negedge clk);
        poll_start = 1'b0;
        wait_fin(r, t);
        chk("R9", "ready", r, 1);
        chk("R9", "probes", probes, 3);
        chk("R9", "done pulses", done_cnt, 1);
    endtask

    task automatic sc_bus_gate;
        int r, t;
        @(negedge clk);
        bus_free = 1'b0;
        launch(2, 0, 0);
        repeat (30) @(negedge clk);
        chk("R3", "probes while bus held", probes, 0);
        chk("R3", "busy while bus held", int'(poll_busy), 1);
        bus_free = 1'b1;
        wait_fin(r, t);
        chk("R3", "ready once bus free", r, 1);
        chk("R3", "start without free bus", bus_err, 0);
    endtask

    task automatic sc_hold;
        repeat (12) @(negedge clk);
        chk("R10", "ready held", int'(poll_ready), 1);
        chk("R10", "timeout held", int'(poll_timeout), 0);
        chk("R10", "done stays low", int'(poll_done), 0);
        chk("R10", "single done pulse", done_cnt, 1);
    endtask

    initial begin
        pend = 0; gap_on = 0; exp_op = 2'd0; probes = 0; done_cnt = 0;
        sc_reset();
        sc_quick_ack();
        sc_nack_then_ack();
        sc_exhaust();
        sc_zero_limit();
        sc_latch();
        sc_busy_start();
        sc_bus_gate();
        sc_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule